// File: doc/BRIEF.md
# Window Watchdog with Reset Pulse Train

This block supervises a periodic "still alive" signal from a processor. Only the falling edges of that signal matter. The block measures the time between consecutive falling edges by counting a synchronous time-base strobe. It then compares the measurement with a minimum and a maximum spacing, both set by parameters.

A spacing that is too short or too long is a fault, and so is an input that stops toggling in either level. While a fault holds, the block drives an active-low reset as a repeating train of equal low and high phases. The train stops once a correctly spaced edge returns, and only at the end of a high phase. A registered fault flag is also provided for the power-control logic.

A parameter selects a reduced variant that checks only the too-slow limit and treats any short spacing as valid. Defaults keep the fixed timing ratios: pulse phase 4 strobes, minimum spacing 15 strobes (about 3.8 phases), maximum spacing 52 strobes (13 phases).

Top module: `wdog_window_rst`

## Requirements
- R1: During reset and afterwards, until a fault is detected, `rst_no` is 1 and `wd_fault_o` is 0.
- R2: The measured interval I is the number of cycles with `tick_i` = 1 strictly between two falling-edge detections of the synchronized `wd_in_i`. With `tick_i` held at 1 and falls P cycles apart, I = P-1. The count does not advance on cycles with `tick_i` = 0.
- R3: `wd_fault_o` becomes 1 when I reaches MAX_TICKS (too slow). It does so without waiting for an edge, so an input stuck at 1 or stuck at 0 raises it.
- R4: With CHECK_FAST = 1, a falling edge with I < MIN_TICKS sets `wd_fault_o` to 1 (too fast).
- R5: With CHECK_FAST = 0, short intervals are valid. Such an input leaves `wd_fault_o` at 0 and `rst_no` at 1.
- R6: The first falling edge after reset only starts a measurement. A later falling edge with an in-window interval (MIN_TICKS <= I < MAX_TICKS, or I < MAX_TICKS when CHECK_FAST = 0) clears `wd_fault_o`.
- R7: While a fault holds, `rst_no` repeats low for UNIT_TICKS strobes, then high for UNIT_TICKS strobes.
- R8: Every low pulse lasts the full UNIT_TICKS strobes. A low pulse starts only while `wd_fault_o` is 1. Once the fault clears, the train ends after the current high phase, and `rst_no` then stays 1.
- R9: The interval counter saturates at MAX_TICKS and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Time-base strobe; all limits are counted in these |
| wd_in_i | input | 1 | Asynchronous watchdog input from the processor |
| rst_no | output | 1 | Active-low reset pulse train |
| wd_fault_o | output | 1 | Registered fault flag |

## Verification
The bench sweeps the edge period across both window limits, one cycle at a time, and checks the full and reduced variants against the arithmetic window. An off-by-one in the counter or the compare would flip the verdict at exactly P = MIN+1 or P = MAX+1. Stuck-high and stuck-low inputs are applied, the strobe is frozen, and it is run at half rate. A counter that ignored the strobe or waited for an edge would miss or invent faults. Every low and high run of the reset is measured during faults and during recovery, so a train that stopped mid-pulse or kept running after recovery would show a wrong run length.

// File: rtl/wdog_window_pkg.sv
package wdog_window_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_edge_sync.sv
module wdog_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[LEN-2:0], async_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign fall_o = sh_q[LEN-1] & ~sh_q[LEN-2];

  AST_FALL_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o) else $error("AST_FALL_SPACED"); // R2
endmodule

// File: rtl/wdog_interval.sv
module wdog_interval #(
  parameter int MIN_TICKS  = 15,
  parameter int MAX_TICKS  = 52,
  parameter bit CHECK_FAST = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fall_i,
  output logic fault_o
);
  localparam int CW = $clog2(MAX_TICKS + 1);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_TICKS);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flt_q, flt_d;
  logic          armed_q, armed_d;
  logic          is_slow, is_fast;

  always_comb begin
    is_slow = (cnt_q == MAX_C);
    is_fast = CHECK_FAST && (cnt_q < MIN_C);
    cnt_d   = cnt_q;
    flt_d   = flt_q;
    armed_d = armed_q | fall_i;
    if (fall_i) begin
      cnt_d = '0;
      if (armed_q) flt_d = is_slow | is_fast;
    end else begin
      if (tick_i && !is_slow) cnt_d = cnt_q + 1'b1;
      if (is_slow) flt_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      flt_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      flt_q   <= flt_d;
      armed_q <= armed_d;
    end
  end

  assign fault_o = flt_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_C) else $error("AST_CNT_BOUND"); // R9
  AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !fall_i) |=> $stable(cnt_q)) else $error("AST_TICK_HOLD"); // R2
  AST_SLOW_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX_C && (armed_q || !fall_i)) |=> flt_q) else $error("AST_SLOW_SETS"); // R3
  AST_FAST_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CHECK_FAST && fall_i && armed_q && cnt_q < MIN_C) |=> flt_q) else $error("AST_FAST_SETS"); // R4
  AST_VALID_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && armed_q && cnt_q < MAX_C && (cnt_q >= MIN_C || !CHECK_FAST)) |=> !flt_q)
    else $error("AST_VALID_CLEARS"); // R6
endmodule

// File: rtl/wdog_pulse_seq.sv
module wdog_pulse_seq
  import wdog_window_pkg::*;
#(
  parameter int UNIT_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fault_i,
  output logic rst_no
);
  localparam int PW = $clog2(UNIT_TICKS + 1);
  localparam logic [PW-1:0] LAST_C = PW'(UNIT_TICKS - 1);

  phase_e        ph_q, ph_d;
  logic [PW-1:0] pc_q, pc_d;
  logic          rst_q, rst_d;

  always_comb begin
    ph_d = ph_q;
    pc_d = pc_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (fault_i) begin
          ph_d = PH_LOW;
          pc_d = '0;
        end
      end
      PH_LOW: begin
        if (tick_i) begin
          if (pc_q == LAST_C) begin
            ph_d = PH_HIGH;
            pc_d = '0;
          end else begin
            pc_d = pc_q + 1'b1;
          end
        end
      end
      PH_HIGH: begin
        if (tick_i) begin
          if (pc_q == LAST_C) begin
            ph_d = fault_i ? PH_LOW : PH_IDLE;
            pc_d = '0;
          end else begin
            pc_d = pc_q + 1'b1;
          end
        end
      end
      default: begin
        ph_d = PH_IDLE;
        pc_d = '0;
      end
    endcase
    rst_d = (ph_d != PH_LOW);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      pc_q  <= '0;
      rst_q <= 1'b1;
    end else begin
      ph_q  <= ph_d;
      pc_q  <= pc_d;
      rst_q <= rst_d;
    end
  end

  assign rst_no = rst_q;

  AST_PHASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q <= LAST_C) else $error("AST_PHASE_BOUND"); // R7
  AST_LOW_NEEDS_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_q) |-> $past(fault_i)) else $error("AST_LOW_NEEDS_FAULT"); // R8
  AST_NO_CUT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_LOW) |=> (ph_q != PH_IDLE)) else $error("AST_NO_CUT_LOW"); // R8
endmodule

// File: rtl/wdog_window_rst.sv
module wdog_window_rst #(
  parameter int UNIT_TICKS = 4,
  parameter int MIN_TICKS  = 15,
  parameter int MAX_TICKS  = 52,
  parameter bit CHECK_FAST = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic wd_in_i,
  output logic rst_no,
  output logic wd_fault_o
);
  logic rst_n_int;
  logic fall;
  logic fault;

  wdog_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_n_int)
  );

  wdog_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .async_i(wd_in_i),
    .fall_o (fall)
  );

  wdog_interval #(
    .MIN_TICKS (MIN_TICKS),
    .MAX_TICKS (MAX_TICKS),
    .CHECK_FAST(CHECK_FAST)
  ) u_interval (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .tick_i (tick_i),
    .fall_i (fall),
    .fault_o(fault)
  );

  wdog_pulse_seq #(.UNIT_TICKS(UNIT_TICKS)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .tick_i (tick_i),
    .fault_i(fault),
    .rst_no (rst_no)
  );

  assign wd_fault_o = fault;

  AST_QUIET_WHEN_OK: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    ($past(!fault) && !fault && rst_no) |=> rst_no) else $error("AST_QUIET_WHEN_OK"); // R8
endmodule

// File: tb/wdog_window_rst_tb.sv
module wdog_window_rst_tb;
  localparam int UNIT = 4;
  localparam int MINT = 15;
  localparam int MAXT = 52;

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic wd;
  logic rst_full_n, flt_full, rst_red_n, flt_red;

  int n_chk = 0;
  int n_bad = 0;
  int tick_mode = 1;
  bit mon_en = 0;
  int lo_run = 0, hi_run = 0;
  bit in_train = 0;
  bit red_low = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  wdog_window_rst #(.UNIT_TICKS(UNIT), .MIN_TICKS(MINT), .MAX_TICKS(MAXT), .CHECK_FAST(1'b1))
  u_dut (.clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wd_in_i(wd),
         .rst_no(rst_full_n), .wd_fault_o(flt_full));

  wdog_window_rst #(.UNIT_TICKS(UNIT), .MIN_TICKS(MINT), .MAX_TICKS(MAXT), .CHECK_FAST(1'b0))
  u_dut_red (.clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wd_in_i(wd),
             .rst_no(rst_red_n), .wd_fault_o(flt_red));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (tick_mode == 0)      tick <= 1'b0;
    else if (tick_mode == 1) tick <= 1'b1;
    else                     tick <= ~tick;
  end

  // run-length monitor of the full variant reset output
  always @(negedge clk) begin
    if (!rst_red_n) red_low = 1'b1;
    if (!mon_en) begin
      lo_run = 0; hi_run = 0; in_train = 0;
    end else if (!rst_full_n) begin
      if (in_train && hi_run != 0) check("R7 high phase", hi_run, UNIT);
      hi_run = 0;
      lo_run++;
      in_train = 1;
    end else begin
      if (lo_run != 0) check("R8 low pulse width", lo_run, UNIT);
      lo_run = 0;
      if (in_train) hi_run++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    mon_en = 0;
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    red_low = 0;
    mon_en = 1;
  endtask

  task automatic wave(input int p, input int periods);
    for (int k = 0; k < periods; k++) begin
      wd = 1'b1;
      wait_cyc(p / 2);
      wd = 1'b0;
      wait_cyc(p - p / 2);
    end
  endtask

  initial begin
    rst_n = 1'b1;
    tick = 1'b1;
    wd = 1'b0;
    #1 rst_n = 1'b0;
    wait_cyc(3);
    check("R1 rst_no in reset", rst_full_n, 1);
    check("R1 fault in reset", flt_full, 0);
    rst_n = 1'b1;
    wait_cyc(10);
    check("R1 rst_no after reset", rst_full_n, 1);
    check("R1 fault after reset", flt_full, 0);

    // period sweep across both limits
    for (int p = 8; p <= 60; p++) begin
      int iv;
      bit ef, er;
      iv = p - 1;
      ef = (iv < MINT) || (iv >= MAXT);
      er = (iv >= MAXT);
      do_reset();
      red_low = 0;
      wave(p, 7);
      if (ef && iv < MINT) check("R4 fast fault full", flt_full, 1);
      else if (ef)         check("R3 slow fault full", flt_full, 1);
      else                 check("R6 valid full", flt_full, 0);
      if (er) check("R3 slow fault reduced", flt_red, 1);
      else    check("R5 reduced no fault", flt_red, 0);
      check("R5 reduced reset train", red_low, er);
    end

    // stuck high then recovery
    do_reset();
    wd = 1'b1;
    wait_cyc(MAXT + 8);
    check("R3 stuck high full", flt_full, 1);
    check("R3 stuck high reduced", flt_red, 1);
    wait_cyc(UNIT * 8);
    check("R7 train running", in_train, 1);
    wave(30, 5);
    check("R6 recovered", flt_full, 0);
    wave(30, 2);
    begin
      bit seen_low;
      seen_low = 0;
      for (int i = 0; i < 240; i++) begin
        if (i % 30 == 0) wd = 1'b1;
        if (i % 30 == 15) wd = 1'b0;
        @(negedge clk);
        if (!rst_full_n) seen_low = 1;
      end
      check("R8 train ended", seen_low, 0);
    end

    // stuck low
    do_reset();
    wd = 1'b0;
    wait_cyc(MAXT + 8);
    check("R3 stuck low full", flt_full, 1);
    wait_cyc(UNIT * 8);
    check("R7 stuck low train", in_train, 1);

    // frozen time base
    do_reset();
    tick_mode = 0;
    wd = 1'b1;
    wait_cyc(300);
    check("R2 frozen tick fault", flt_full, 0);
    check("R2 frozen tick reset", rst_full_n, 1);
    tick_mode = 1;
    wait_cyc(MAXT + 8);
    check("R2 resumed tick fault", flt_full, 1);

    // half-rate time base
    do_reset();
    mon_en = 0;
    tick_mode = 2;
    wave(60, 7);
    check("R2 half rate valid", flt_full, 0);
    wave(20, 7);
    check("R4 half rate fast", flt_full, 1);
    check("R5 half rate fast reduced", flt_red, 0);
    wave(120, 4);
    check("R3 half rate slow", flt_full, 1);
    tick_mode = 1;

    do_reset();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule